// File: doc/BRIEF.md
# Predecoding Instruction Cache Fill

This block is a small direct-mapped instruction cache that computes length
information while a line is being filled. When memory returns a line of
instruction bytes, every byte is examined as though an instruction began
there, and a five-bit marker is produced for it in the same cycle. The marker
holds the distance to the next instruction start and a flag for an instruction
that runs past the end of the line. The byte and its marker are written together
into one widened array entry, so no extra pipeline stage is needed.

A fetch looks up the line addressed by `fetch_addr` combinationally. On a hit
the block returns all sixteen bytes and their sixteen markers, and decoders can
then locate instruction starts in parallel. On a miss it raises a line request
that carries the aligned line address. The fill comes back as a single beat with
a strobe. The tag, valid bit, bytes and markers are all written on that one
clock edge.

The length rule is deliberately simple. The low nibble of a byte gives the
instruction length, from 1 to 15, and a nibble of zero counts as length 1.

Top module: `icpd_fill_cache`

## Requirements
- R1: A synchronous active-low reset clears every valid bit, so that each fetch after reset misses until its line is filled again.
- R2: While `fetch_req` is high and the lookup misses, `fill_req` is high in the same cycle. `fill_req_addr` then equals `fetch_addr` with its low 4 bits cleared. `fill_req` is low whenever `fetch_req` is low or the lookup hits.
- R3: A fill beat (`fill_valid` high) writes the tag, valid bit, bytes and markers on one clock edge. From the next cycle, a fetch of that line hits and returns the filled bytes unchanged in `fetch_bytes`, with byte i at bits [8i+7:8i].
- R4: Marker bits [3:0] for byte i (in `fetch_pd` bits [5i+4:5i]) equal the byte's low nibble, or 1 when that nibble is zero.
- R5: Marker bit 4 for byte i is set exactly when i plus the length from R4 is 16 or more. Byte 15 therefore always has it set, and byte 0 never does.
- R6: Markers are computed for every byte of the line, so a fetch at any offset within the line returns the same bytes and markers as a fetch at offset 0.
- R7: Placement is direct-mapped with 32 sets. The set is `addr[8:4]` and the tag is `addr[31:9]`. A fill to a set replaces the line that was held there before.
- R8: A fetch presented in the same cycle as a fill of its line sees the contents from before the fill, and it hits from the following cycle.
- R9: A fetch whose set is valid but whose tag differs misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Fetch lookup strobe |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_hit | output | 1 | Lookup hit |
| fetch_bytes | output | 128 | Sixteen line bytes, byte 0 lowest |
| fetch_pd | output | 80 | Sixteen five-bit markers, byte 0 lowest |
| fill_req | output | 1 | Line request on a miss |
| fill_req_addr | output | 32 | Line-aligned address of the request |
| fill_valid | input | 1 | Fill beat strobe |
| fill_addr | input | 32 | Address of the line being filled |
| fill_data | input | 128 | Line bytes being filled, byte 0 lowest |

## Verification
A fill and a lookup can land in the same cycle, and the lookup may target the very set being written. The bench provokes this by holding a fetch of a line on the same cycle as that line's fill beat. It judges the result in two steps. During the beat the fetch must still miss and raise a request. In the very next cycle, with no further stimulus, the same fetch must hit with the filled bytes and the markers computed for them.

// File: rtl/icpd_pkg.sv
// Package: shared constants for the predecoding instruction cache.
// Assumes an 8-bit byte and a length field held in the low nibble of a byte.
package icpd_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 4;
    localparam int PD_W   = LEN_W + 1;   // distance plus line-crossing flag
endpackage

// File: rtl/icpd_predecode.sv
// Module: icpd_predecode
// Computes, for every byte of a line, a marker {cross, distance}. The distance
// is the byte's low nibble, with zero promoted to one. Cross is set when the
// next start lies past the end of the line.
// Assumes every byte could be an instruction start; purely combinational.
module icpd_predecode
    import icpd_pkg::*;
#(
    parameter int LINE_BYTES = 16
) (
    input  logic [LINE_BYTES*BYTE_W-1:0] line_i,
    output logic [LINE_BYTES*PD_W-1:0]   pd_o
);
    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        logic [LEN_W-1:0] nib;
        logic [LEN_W-1:0] len;
        logic [31:0]      nxt;
        // per-byte length, next-start position and marker
        always_comb begin
            nib = line_i[g*BYTE_W +: LEN_W];
            len = (nib == '0) ? LEN_W'(1) : nib;
            nxt = 32'(g) + 32'(len);
            pd_o[g*PD_W +: PD_W] = {(nxt >= 32'(LINE_BYTES)), len};
        end
        logic unused_hi;
        assign unused_hi = ^line_i[g*BYTE_W+LEN_W +: BYTE_W-LEN_W];
    end
endmodule

// File: rtl/icpd_tag_array.sv
// Module: icpd_tag_array
// Holds the valid bit and tag for each set of a direct-mapped cache and
// compares them against a lookup. The read is combinational, and the write
// lands on the clock edge. Assumes one write port and one read port.
module icpd_tag_array #(
    parameter int SETS  = 32,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_match,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // valid bits: cleared by reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // tag storage: written by a fill, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    // lookup: valid entry with equal tag
    assign rd_match = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    // R3
    fill_sets_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));
endmodule

// File: rtl/icpd_data_array.sv
// Module: icpd_data_array
// Widened line storage that holds the bytes and their markers in one word
// per set. The read is combinational, and the write lands on the clock edge.
// Assumes the whole line is written at once.
module icpd_data_array #(
    parameter int SETS   = 32,
    parameter int WORD_W = 208,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [SETS];

    // line write: bytes and markers together
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_word;
    end

    // line read
    assign rd_word = mem_q[rd_idx];

    // R3
    word_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_word)));
endmodule

// File: rtl/icpd_fill_cache.sv
// Module: icpd_fill_cache (top)
// Direct-mapped instruction cache that predecodes each line while it is
// filled and returns bytes and markers together on a hit. Assumes a
// single-beat fill and a combinational lookup; the fill request is combinational.
module icpd_fill_cache
    import icpd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_req,
    input  logic [ADDR_W-1:0]            fetch_addr,
    output logic                         fetch_hit,
    output logic [LINE_BYTES*BYTE_W-1:0] fetch_bytes,
    output logic [LINE_BYTES*PD_W-1:0]   fetch_pd,
    output logic                         fill_req,
    output logic [ADDR_W-1:0]            fill_req_addr,
    input  logic                         fill_valid,
    input  logic [ADDR_W-1:0]            fill_addr,
    input  logic [LINE_BYTES*BYTE_W-1:0] fill_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int DATA_W = LINE_BYTES * BYTE_W;
    localparam int PDV_W  = LINE_BYTES * PD_W;
    localparam int WORD_W = DATA_W + PDV_W;

    logic [IDX_W-1:0]  f_idx, w_idx;
    logic [TAG_W-1:0]  f_tag, w_tag;
    logic [PDV_W-1:0]  fill_pd;
    logic [WORD_W-1:0] rd_word;
    logic              tag_match;

    // address split for the lookup and the fill
    assign f_idx = fetch_addr[OFF_W +: IDX_W];
    assign f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
    assign w_idx = fill_addr[OFF_W +: IDX_W];
    assign w_tag = fill_addr[ADDR_W-1 -: TAG_W];

    logic unused_offs;
    assign unused_offs = ^{fill_addr[OFF_W-1:0], fetch_addr[OFF_W-1:0]};

    icpd_predecode #(.LINE_BYTES(LINE_BYTES)) u_predecode (
        .line_i (fill_data),
        .pd_o   (fill_pd)
    );

    icpd_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_tag   (f_tag),
        .rd_match (tag_match),
        .wr_en    (fill_valid),
        .wr_idx   (w_idx),
        .wr_tag   (w_tag)
    );

    icpd_data_array #(.SETS(SETS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_valid),
        .wr_idx  (w_idx),
        .wr_word ({fill_pd, fill_data}),
        .rd_idx  (f_idx),
        .rd_word (rd_word)
    );

    // fetch result and miss request
    always_comb begin
        fetch_hit     = fetch_req && tag_match;
        fill_req      = fetch_req && !tag_match;
        fill_req_addr = {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        fetch_bytes   = rd_word[DATA_W-1:0];
        fetch_pd      = rd_word[WORD_W-1:DATA_W];
    end

    // R5
    last_byte_crosses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> fetch_pd[LINE_BYTES*PD_W-1]);

    // R5
    first_byte_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> !fetch_pd[PD_W-1]);

    // R2
    no_request_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> !fill_req);
endmodule

// File: tb/test_icpd_fill_cache.sv
// Directed bench for icpd_fill_cache: one task per scenario.
module test_icpd_fill_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_req = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_hit;
    logic [127:0] fetch_bytes;
    logic [79:0]  fetch_pd;
    logic         fill_req;
    logic [31:0]  fill_req_addr;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [127:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    icpd_fill_cache i_icpd_fill_cache (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_hit(fetch_hit), .fetch_bytes(fetch_bytes), .fetch_pd(fetch_pd),
        .fill_req(fill_req), .fill_req_addr(fill_req_addr), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [127:0] mk_line(input logic [7:0] seed);
        logic [127:0] l;
        for (int i = 0; i < 16; i++) l[i*8 +: 8] = 8'(i * 37) + seed;
        return l;
    endfunction

    function automatic logic [79:0] exp_pd(input logic [127:0] l);
        logic [79:0] p;
        for (int i = 0; i < 16; i++) begin
            logic [3:0] n;
            n = l[i*8 +: 4];
            if (n == 0) n = 4'd1;
            p[i*5 +: 5] = {((i + int'(n)) >= 16), n};
        end
        return p;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; fetch_req = 1'b0; fill_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [127:0] d);
        @(negedge clk); fill_valid = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk); fill_valid = 1'b0;
    endtask

    // drive a fetch at a falling edge and let outputs settle
    task automatic look(input logic [31:0] a);
        @(negedge clk); fetch_req = 1'b1; fetch_addr = a; #1;
    endtask

    task automatic t_reset_miss();
        look(32'h0000_1234);
        chk("R1 hit after reset", 128'(fetch_hit), 128'(0));
        chk("R2 request on miss", 128'(fill_req), 128'(1));
        chk("R2 request address", 128'(fill_req_addr), 128'(32'h0000_1230));
        @(negedge clk); fetch_req = 1'b0; #1;
        chk("R2 no request when idle", 128'(fill_req), 128'(0));
    endtask

    task automatic t_fill_hit(input logic [31:0] a, input logic [127:0] d);
        do_fill(a, d);
        look(a);
        chk("R3 hit after fill", 128'(fetch_hit), 128'(1));
        chk("R2 no request on hit", 128'(fill_req), 128'(0));
        chk("R3 bytes", fetch_bytes, d);
        chk("R4 R5 markers", 128'(fetch_pd), 128'(exp_pd(d)));
    endtask

    task automatic t_offset(input logic [31:0] a, input logic [127:0] d);
        look(a + 32'd7);
        chk("R6 hit at offset", 128'(fetch_hit), 128'(1));
        chk("R6 bytes at offset", fetch_bytes, d);
        chk("R6 markers at offset", 128'(fetch_pd), 128'(exp_pd(d)));
    endtask

    task automatic t_extremes();
        logic [79:0] e0, ef;
        for (int i = 0; i < 16; i++) begin
            e0[i*5 +: 5] = {(i == 15), 4'd1};
            ef[i*5 +: 5] = {(i >= 1), 4'd15};
        end
        do_fill(32'h0000_0400, '0);
        look(32'h0000_0400);
        chk("R4 zero nibble counts as one", 128'(fetch_pd), 128'(e0));
        do_fill(32'h0000_0410, {16{8'hFF}});
        look(32'h0000_0410);
        chk("R5 longest length crosses", 128'(fetch_pd), 128'(ef));
    endtask

    task automatic t_conflict();
        logic [127:0] d1, d2;
        d1 = mk_line(8'h11); d2 = mk_line(8'h5A);
        do_fill(32'h0000_2050, d1);
        look(32'h0000_4050);   // same set 5, other tag
        chk("R9 tag mismatch misses", 128'(fetch_hit), 128'(0));
        do_fill(32'h0000_4050, d2);
        look(32'h0000_4050);
        chk("R7 new line hits", fetch_bytes, d2);
        look(32'h0000_2050);
        chk("R7 old line evicted", 128'(fetch_hit), 128'(0));
        look(32'h0000_4060);   // set 6, never filled
        chk("R7 other set misses", 128'(fetch_hit), 128'(0));
    endtask

    task automatic t_same_cycle();
        logic [127:0] d;
        d = mk_line(8'h33);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 32'h0000_81F4;
        fill_valid = 1'b1; fill_addr = 32'h0000_81F0; fill_data = d; #1;
        chk("R8 miss during fill", 128'(fetch_hit), 128'(0));
        chk("R8 request during fill", 128'(fill_req), 128'(1));
        @(negedge clk); fill_valid = 1'b0; #1;
        chk("R8 hit next cycle", 128'(fetch_hit), 128'(1));
        chk("R8 markers next cycle", 128'(fetch_pd), 128'(exp_pd(d)));
    endtask

    task automatic t_reset_again();
        do_reset();
        look(32'h0000_1230);
        chk("R1 reset clears filled line", 128'(fetch_hit), 128'(0));
    endtask

    initial begin
        do_reset();
        t_reset_miss();
        t_fill_hit(32'h0000_1230, mk_line(8'h20));
        t_offset(32'h0000_1230, mk_line(8'h20));
        t_fill_hit(32'hFFFF_FFF0, mk_line(8'hC3));
        t_extremes();
        t_conflict();
        t_same_cycle();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule